// File: doc/BRIEF.md
# SPI Register Access Engine

This block is a hardware SPI master for reading and writing 16-bit registers in an Ethernet controller attached over SPI. A host hands it one request at a time through a valid/ready handshake. Each request carries an 8-bit register address, a write flag and 16 bits of write data. The engine builds a 16-bit command word from the address and the direction. It frames a fixed 32-bit exchange under an active-low chip select and shifts it out over SCLK and MOSI, while it captures MISO.

An overrun indication can arrive while an exchange is running. In that case the engine runs the same exchange again after a short chip-select-high gap, up to a fixed total number of attempts. When the last attempt finishes, it pulses a completion strobe whether or not that attempt was clean. With the strobe it presents the 16-bit read value assembled from the last two received bytes.

Top module: `spi_reg_engine`

## Requirements
- R1: While reset is held, and right after it, chip select is high, SCLK is low, the request port is ready and the completion strobe is low.
- R2: The command word holds the opcode in bits 15..14 (00 for read, 01 for write), the byte-enable field in bits 13..10, address bits 7..0 in bits 9..2, and zero in bits 1..0.
- R3: The byte-enable field is 4'b1100 when address bit 1 is set and 4'b0011 when it is clear.
- R4: Each chip-select window carries exactly 32 bits, in this byte order: command high byte, command low byte, write data low byte, write data high byte. Each byte is sent MSB first.
- R5: A read sends 8'h00 in both data byte slots. Its result is {fourth received byte, third received byte}.
- R6: SCLK idles low. MOSI changes only together with a rising SCLK edge. MISO is captured at the falling edge. Each SCLK high and low phase lasts CLK_DIV system clocks.
- R7: Chip select stays low for the whole 32-bit exchange, and SCLK is high only while chip select is low.
- R8: If the overrun input is seen during an attempt, the exchange is repeated with the identical frame, up to MAX_TRIES (default 3) attempts in total.
- R9: The completion strobe is a single-cycle pulse issued once per request, after the final attempt, even when that attempt saw an overrun. The request port is ready only while the engine is idle.
- R10: An overrun that is asserted while no exchange is running has no effect: the next request takes exactly one attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Engine idle, request accepted when valid |
| req_addr_i | input | 8 | Register address |
| req_we_i | input | 1 | 1 for write, 0 for read |
| req_wdata_i | input | 16 | Write data |
| rsp_done_o | output | 1 | One-cycle completion strobe |
| rsp_rdata_o | output | 16 | Read value of the last attempt |
| ovr_i | input | 1 | Overrun indication |
| spi_sclk_o | output | 1 | SPI clock, idle low |
| spi_cs_no | output | 1 | Chip select, active low |
| spi_mosi_o | output | 1 | Serial data to the device |
| spi_miso_i | input | 1 | Serial data from the device |

## Verification
Writes and reads are issued to addresses with bit 1 clear and with bit 1 set. Each captured frame then shows whether the byte-enable choice and the address placement are correct. Asymmetric write data, and device responses whose bytes all differ, expose any swap of the data bytes or of the two received bytes. Overrun patterns hit only the first attempt, the first two, or every attempt, which separates a retry that stops correctly from one that stops early or runs past the cap. An overrun while idle confirms that no stale flag carries into the next request.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 16;
  localparam int CMD_W   = 16;
  localparam int FRAME_W = CMD_W + DATA_W;

  localparam logic [1:0] OP_RD = 2'b00;
  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [3:0] BE_HI = 4'b1100;
  localparam logic [3:0] BE_LO = 4'b0011;
  localparam logic [7:0] DUMMY = 8'h00;

  typedef enum logic [2:0] {SH_IDLE, SH_LEAD, SH_HIGH, SH_LOW, SH_TAIL} sh_state_e;
  typedef enum logic [1:0] {EN_IDLE, EN_LAUNCH, EN_RUN, EN_GAP} en_state_e;
endpackage

// File: rtl/spi_frame_enc.sv
module spi_frame_enc
  import spi_eng_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [CMD_W-1:0]  cmd;
  logic [DATA_W-1:0] data;

  always_comb begin
    cmd  = {(we_i ? OP_WR : OP_RD), (addr_i[1] ? BE_HI : BE_LO), addr_i, 2'b00};
    data = we_i ? wdata_i : {DUMMY, DUMMY};
    // command MSB byte first, data LSB byte first
    frame_o = {cmd[15:8], cmd[7:0], data[7:0], data[15:8]};
  end
endmodule

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int CLK_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CNT_W'(CLK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!en_i || tick_o) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit
  import spi_eng_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [FRAME_W-1:0] rx_o,
  output logic               sclk_o,
  output logic               cs_no,
  output logic               mosi_o,
  input  logic               miso_i
);
  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  sh_state_e          st_q;
  logic [FRAME_W-1:0] tx_q, rx_q;
  logic [BIT_W-1:0]   bit_q;
  logic               tick;

  spi_tick_gen #(.CLK_DIV(CLK_DIV)) i_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (busy_o),
    .tick_o(tick)
  );

  assign busy_o = (st_q != SH_IDLE);
  assign done_o = (st_q == SH_TAIL) && tick;
  assign rx_o   = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SH_IDLE;
      tx_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
      sclk_o <= 1'b0;
      cs_no  <= 1'b1;
      mosi_o <= 1'b0;
    end else begin
      case (st_q)
        SH_IDLE: if (start_i) begin
          tx_q  <= frame_i;
          bit_q <= '0;
          cs_no <= 1'b0;
          st_q  <= SH_LEAD;
        end
        SH_LEAD, SH_LOW: if (tick) begin
          sclk_o <= 1'b1;
          mosi_o <= tx_q[FRAME_W-1];
          tx_q   <= {tx_q[FRAME_W-2:0], 1'b0};
          st_q   <= SH_HIGH;
        end
        SH_HIGH: if (tick) begin
          sclk_o <= 1'b0;
          rx_q   <= {rx_q[FRAME_W-2:0], miso_i};
          if (bit_q == LAST_BIT) st_q <= SH_TAIL;
          else begin
            bit_q <= bit_q + 1'b1;
            st_q  <= SH_LOW;
          end
        end
        SH_TAIL: if (tick) begin
          cs_no <= 1'b1;
          st_q  <= SH_IDLE;
        end
        default: st_q <= SH_IDLE;
      endcase
    end
  end

  // R7
  sclk_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_no);
  // R6
  mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(sclk_o) |-> $stable(mosi_o));
  // R7
  cs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && st_q != SH_TAIL) |=> !cs_no);
endmodule

// File: rtl/spi_reg_engine.sv
module spi_reg_engine
  import spi_eng_pkg::*;
#(
  parameter int CLK_DIV   = 2,
  parameter int MAX_TRIES = 3,
  parameter int GAP_CYC   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_we_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_done_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic              ovr_i,
  output logic              spi_sclk_o,
  output logic              spi_cs_no,
  output logic              spi_mosi_o,
  input  logic              spi_miso_i
);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam int GAP_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

  en_state_e          st_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               we_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [TRY_W-1:0]   tries_q;
  logic [GAP_W-1:0]   gap_q;
  logic               ovr_q, done_q;
  logic [DATA_W-1:0]  rdata_q;
  logic [FRAME_W-1:0] frame, rx;
  logic               sh_busy, sh_done, ovr_hit;

  spi_frame_enc i_enc (
    .addr_i (addr_q),
    .we_i   (we_q),
    .wdata_i(wdata_q),
    .frame_o(frame)
  );

  spi_shift_unit #(.CLK_DIV(CLK_DIV)) i_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(st_q == EN_LAUNCH),
    .frame_i(frame),
    .busy_o (sh_busy),
    .done_o (sh_done),
    .rx_o   (rx),
    .sclk_o (spi_sclk_o),
    .cs_no  (spi_cs_no),
    .mosi_o (spi_mosi_o),
    .miso_i (spi_miso_i)
  );

  assign req_ready_o = (st_q == EN_IDLE);
  assign rsp_done_o  = done_q;
  assign rsp_rdata_o = rdata_q;
  assign ovr_hit     = ovr_q | ovr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= EN_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      tries_q <= '0;
      gap_q   <= '0;
      ovr_q   <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        EN_IDLE: if (req_valid_i) begin
          addr_q  <= req_addr_i;
          we_q    <= req_we_i;
          wdata_q <= req_wdata_i;
          tries_q <= '0;
          st_q    <= EN_LAUNCH;
        end
        EN_LAUNCH: begin
          ovr_q <= 1'b0;
          st_q  <= EN_RUN;
        end
        EN_RUN: begin
          if (ovr_i) ovr_q <= 1'b1;
          if (sh_done) begin
            tries_q <= tries_q + 1'b1;
            // third received byte is low, fourth is high
            rdata_q <= {rx[7:0], rx[15:8]};
            if (ovr_hit && tries_q < TRY_W'(MAX_TRIES - 1)) begin
              gap_q <= '0;
              st_q  <= EN_GAP;
            end else begin
              done_q <= 1'b1;
              st_q   <= EN_IDLE;
            end
          end
        end
        EN_GAP: begin
          if (gap_q == GAP_W'(GAP_CYC - 1)) st_q <= EN_LAUNCH;
          else gap_q <= gap_q + 1'b1;
        end
        default: st_q <= EN_IDLE;
      endcase
    end
  end

  // R8
  tries_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tries_q <= TRY_W'(MAX_TRIES));
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o);
  // R9
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (spi_cs_no && !sh_busy));
  // R8
  retry_after_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == EN_GAP) |-> spi_cs_no);
endmodule

// File: tb/test_spi_reg_engine.sv
module test_spi_reg_engine;
  localparam int CLK_DIV = 2;
  localparam int GAP_CYC = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_we_i = 1'b0;
  logic [7:0]  req_addr_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic ovr_i = 1'b0, spi_miso_i = 1'b0;
  logic req_ready_o, rsp_done_o, spi_sclk_o, spi_cs_no, spi_mosi_o;
  logic [15:0] rsp_rdata_o;

  int n_tests = 0, n_fail = 0, inv_fail = 0;
  int n_frames, done_cnt, bit_idx, hi_len;
  logic [31:0] frames [4];
  int          fbits  [4];
  logic [31:0] cap, resp_word;
  logic [2:0]  ovr_mask;
  logic        force_ovr = 1'b0;
  logic [15:0] got_rdata;
  logic        prev_cs = 1'b1, prev_sclk = 1'b0;

  always #5 clk = ~clk;

  spi_reg_engine #(.CLK_DIV(CLK_DIV), .MAX_TRIES(3), .GAP_CYC(GAP_CYC)) i_spi_reg_engine (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_we_i(req_we_i), .req_wdata_i(req_wdata_i),
    .rsp_done_o(rsp_done_o), .rsp_rdata_o(rsp_rdata_o), .ovr_i(ovr_i),
    .spi_sclk_o(spi_sclk_o), .spi_cs_no(spi_cs_no),
    .spi_mosi_o(spi_mosi_o), .spi_miso_i(spi_miso_i)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // device model and per-clock comparison
  always @(negedge clk) begin
    ovr_i = force_ovr;
    if (rst_ni) begin
      if (prev_cs && !spi_cs_no) begin
        bit_idx = 0; cap = '0;
        if (n_frames < 3 && ovr_mask[n_frames]) ovr_i = 1'b1;
      end
      if (!prev_sclk && spi_sclk_o) begin
        spi_miso_i = (bit_idx < 32) ? resp_word[31 - bit_idx] : 1'b0;
        hi_len = 1;
      end else if (spi_sclk_o) hi_len++;
      if (prev_sclk && !spi_sclk_o) begin
        cap = {cap[30:0], spi_mosi_o};
        bit_idx++;
        if (hi_len != CLK_DIV) begin
          inv_fail++; $display("FAIL R6: sclk high %0d expected %0d", hi_len, CLK_DIV);
        end
      end
      if (!prev_cs && spi_cs_no) begin
        if (n_frames < 4) begin frames[n_frames] = cap; fbits[n_frames] = bit_idx; end
        n_frames++;
      end
      if (spi_sclk_o && spi_cs_no) begin
        inv_fail++; $display("FAIL R7: sclk 1 with cs high, expected sclk 0");
      end
      if (req_ready_o && !spi_cs_no) begin
        inv_fail++; $display("FAIL R9: ready 1 during frame, expected 0");
      end
      if (rsp_done_o) begin done_cnt++; got_rdata = rsp_rdata_o; end
    end
    prev_cs = spi_cs_no; prev_sclk = spi_sclk_o;
  end

  function automatic logic [31:0] exp_frame(input logic [7:0] a, input logic we, input logic [15:0] d);
    logic [15:0] cmd;
    logic [15:0] dd;
    cmd = (we ? 16'h4000 : 16'h0000) + (a[1] ? 16'h3000 : 16'h0C00) + (16'(a) * 4);
    dd  = we ? d : 16'h0000;
    return {cmd[15:8], cmd[7:0], dd[7:0], dd[15:8]};
  endfunction

  task automatic txn(input string tag, input logic [7:0] a, input logic we, input logic [15:0] d,
                     input logic [31:0] resp, input logic [2:0] mask);
    int k, exp_n, waitc;
    n_frames = 0; done_cnt = 0; ovr_mask = mask; resp_word = resp;
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    req_valid_i = 1'b1; req_addr_i = a; req_we_i = we; req_wdata_i = d;
    @(negedge clk);
    req_valid_i = 1'b0;
    waitc = 0;
    while (done_cnt == 0 && waitc < 2000) begin @(negedge clk); waitc++; end
    repeat (GAP_CYC + 4 * CLK_DIV + 4) @(negedge clk);
    k = 0;
    while (k < 3 && mask[k]) k++;
    exp_n = (k == 3) ? 3 : k + 1;
    check({tag, " R8 attempts"}, n_frames, exp_n);
    check({tag, " R9 done pulses"}, done_cnt, 1);
    for (int i = 0; i < exp_n && i < 4; i++) begin
      check({tag, " R4 bits per frame"}, fbits[i], 32);
      check({tag, " R2 R3 frame"}, frames[i], exp_frame(a, we, d));
    end
    if (!we) check({tag, " R5 read data"}, got_rdata, {resp[7:0], resp[15:8]});
    check({tag, " R9 ready after"}, req_ready_o, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_frames = 0; done_cnt = 0; ovr_mask = '0; resp_word = '0; cap = '0; bit_idx = 0; hi_len = 0;
    repeat (3) @(negedge clk);
    // R1
    check("R1 cs", spi_cs_no, 1'b1);
    check("R1 sclk", spi_sclk_o, 1'b0);
    check("R1 done", rsp_done_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 ready", req_ready_o, 1'b1);

    txn("wr_be_lo", 8'h10, 1'b1, 16'hBEEF, 32'h0, 3'b000);
    txn("wr_be_hi", 8'h22, 1'b1, 16'h1234, 32'h0, 3'b000);
    txn("rd_be_lo", 8'h00, 1'b0, 16'hFFFF, 32'hA5A5_C37E, 3'b000);
    txn("rd_be_hi", 8'hFE, 1'b0, 16'h0, 32'h1122_9D04, 3'b000);
    txn("rd_retry1", 8'h92, 1'b0, 16'h0, 32'h0F0F_6A51, 3'b001);
    txn("wr_retry2", 8'h44, 1'b1, 16'h8001, 32'h0, 3'b011);
    txn("wr_retry_cap", 8'h3A, 1'b1, 16'h5AC3, 32'h0, 3'b111);
    // R10: overrun while idle
    @(negedge clk); force_ovr = 1'b1;
    repeat (3) @(negedge clk); force_ovr = 1'b0;
    txn("R10 idle_ovr", 8'h06, 1'b1, 16'h7E81, 32'h0, 3'b000);

    check("R6 R7 R9 per-clock invariants", inv_fail, 0);
    n_fail += inv_fail;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule